// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of event timers and the interrupt lines of a chip. Each timer reports a fire event or a clear event. The block turns those events into activity on one of 32 interrupt output lines, and it keeps a per-timer interrupt status register that software clears by writing ones. Each timer has its own route field, an enable bit, a level/edge selector and a message-delivery enable. The block also takes a global enable and a legacy-replacement mode bit.

In legacy-replacement mode, timers 0 and 1 leave their route fields and drive fixed lines. The two external legacy interrupt inputs, the interval-timer input and the real-time-clock input, are then cut off from those lines. Outside legacy mode, both inputs pass through to the same two lines. Lines at index 16 and above are active-low.

All pins are plain level or single-cycle strobe signals. No data stream crosses the block's edge, so there is no back-pressure. Every event is absorbed in the cycle it is presented, and every output is registered.

Top module: `tir_irq_router`

## Requirements
- R1: Outside legacy mode, a timer drives the line whose index equals its 5-bit route field (0 to 31).
- R2: In legacy mode, timer 0 drives line 0 and timer 1 drives line 8 whatever their route fields hold. Timers 2 and up keep using their route fields.
- R3: A level-mode fire from an enabled timer (timer enable and global enable both 1, message delivery off) sets the timer's status bit. It also holds its line asserted until a clear happens.
- R4: An edge-mode fire asserts the line for exactly one cycle and leaves the timer's status bit at 0.
- R5: Lines 16 to 31 are inverted: asserted drives 0 and idle drives 1. After reset, irq_o is 32'hFFFF0000, sts_o is 0 and pit_en_o is 1.
- R6: Writing the status register (sts_wr_i) is write-one-to-clear. A 1 on a bit that is set clears it and deasserts that timer's line. A 0 bit changes nothing.
- R7: A fire while the timer's enable or the global enable is 0 clears the timer's status bit and deasserts its line.
- R8: A clear event (clr_i) clears the timer's status bit and deasserts its line.
- R9: Entering legacy mode drives pit_en_o to 0 and lowers lines 0 and 8. Leaving it lowers line 0, drives pit_en_o to 1, and drives line 8 to the current real-time-clock input level.
- R10: Outside legacy mode, every change of pit_in_i is copied to line 0. In legacy mode that input has no effect on line 0.
- R11: The real-time-clock input is tracked at all times. Each change is copied to line 8 only outside legacy mode.
- R12: A fire from a timer with message delivery enabled touches neither its line nor its status bit. The rising edge of its message-delivery enable deasserts its line and clears its status bit.
- R13: When one line receives an assert and a deassert in the same cycle, the assert wins. All results appear on the outputs after the first clock edge that samples the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | NUM_TIMERS | Per-timer fire strobe |
| clr_i | input | NUM_TIMERS | Per-timer deassert strobe |
| tmr_en_i | input | NUM_TIMERS | Per-timer enable |
| tmr_level_i | input | NUM_TIMERS | 1 = level signalling, 0 = edge |
| tmr_msg_en_i | input | NUM_TIMERS | Per-timer message-delivery enable |
| tmr_route_i | input | NUM_TIMERS*ROUTE_W | Route fields, timer t at bits [t*ROUTE_W +: ROUTE_W] |
| glb_en_i | input | 1 | Global enable |
| legacy_i | input | 1 | Legacy-replacement mode |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | NUM_TIMERS | Status write data, one bit per timer |
| pit_in_i | input | 1 | External interval-timer interrupt level |
| rtc_in_i | input | 1 | External real-time-clock interrupt level |
| irq_o | output | 2**ROUTE_W | Interrupt lines, index 16 and up active-low |
| pit_en_o | output | 1 | Interval-timer enable, low in legacy mode |
| sts_o | output | NUM_TIMERS | Interrupt status register |

## Verification
Every result is due exactly one clock edge after the edge that samples its stimulus: line levels, status bits, the pit_en_o level and the legacy entry/exit effects alike. An edge-mode pulse is gone again one edge later. The bench changes inputs 1 ns after a rising edge and samples all outputs 1 ns after the next rising edge, so each comparison lands in the single cycle where the result must show. A pulse check on the following cycle confirms it has ended. A cycle model in the bench advances in step with each edge and is compared every cycle.

// File: rtl/tir_pkg.sv
package tir_pkg;

  // action a timer requests on its selected line in one cycle
  typedef enum logic [1:0] {
    PIN_IDLE  = 2'd0,
    PIN_HOLD  = 2'd1,
    PIN_PULSE = 2'd2,
    PIN_DROP  = 2'd3
  } pin_act_e;

  // write-one-to-clear hit on a status bit
  function automatic logic w1c_hit(input logic wr, input logic wbit, input logic cur);
    return wr & wbit & cur;
  endfunction

endpackage

// File: rtl/tir_timer_slot.sv
module tir_timer_slot
  import tir_pkg::*;
#(
  parameter int IDX        = 0,
  parameter int ROUTE_W    = 5,
  parameter int LEG_LINE_A = 0,
  parameter int LEG_LINE_B = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire_i,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    level_i,
  input  logic                    msg_en_i,
  input  logic [ROUTE_W-1:0]      route_i,
  input  logic                    glb_en_i,
  input  logic                    legacy_i,
  input  logic                    sts_wr_i,
  input  logic                    sts_wbit_i,
  output logic                    sts_o,
  output logic [(1<<ROUTE_W)-1:0] set_o,
  output logic [(1<<ROUTE_W)-1:0] pls_o,
  output logic [(1<<ROUTE_W)-1:0] drop_o
);

  localparam int NUM_LINES = 1 << ROUTE_W;

  logic         msg_q;
  logic         sts_q;
  logic         armed;
  logic         live;
  logic         msg_rise;
  logic         drop;
  logic         pin_drop;
  logic         sts_nx;
  pin_act_e     act;
  logic [ROUTE_W-1:0] eff_route;

  // legacy override only exists for the first two timers
  generate
    if (IDX == 0) begin : g_leg_a
      assign eff_route = legacy_i ? ROUTE_W'(LEG_LINE_A) : route_i;
    end else if (IDX == 1) begin : g_leg_b
      assign eff_route = legacy_i ? ROUTE_W'(LEG_LINE_B) : route_i;
    end else begin : g_plain
      assign eff_route = route_i;
    end
  endgenerate

  always_comb begin
    armed    = en_i & glb_en_i;
    live     = fire_i & armed & ~msg_en_i;
    msg_rise = msg_en_i & ~msg_q;
    drop     = clr_i | w1c_hit(sts_wr_i, sts_wbit_i, sts_q)
             | (fire_i & ~armed) | msg_rise;
    pin_drop = (drop & ~msg_en_i) | msg_rise;
  end

  always_comb begin
    if (live) begin
      act = level_i ? PIN_HOLD : PIN_PULSE;
    end else if (pin_drop) begin
      act = PIN_DROP;
    end else begin
      act = PIN_IDLE;
    end
  end

  always_comb begin
    if (live && level_i) begin
      sts_nx = 1'b1;
    end else if (live || drop) begin
      sts_nx = 1'b0;
    end else begin
      sts_nx = sts_q;
    end
  end

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      set_o[l]  = (eff_route == ROUTE_W'(l)) && (act == PIN_HOLD);
      pls_o[l]  = (eff_route == ROUTE_W'(l)) && (act == PIN_PULSE);
      drop_o[l] = (eff_route == ROUTE_W'(l)) && (act == PIN_DROP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      msg_q <= msg_en_i;
      sts_q <= sts_nx;
    end
  end

  assign sts_o = sts_q;

endmodule

// File: rtl/tir_legacy_ctl.sv
module tir_legacy_ctl #(
  parameter int NUM_LINES = 32,
  parameter int PIT_LINE  = 0,
  parameter int RTC_LINE  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 legacy_i,
  input  logic                 pit_in_i,
  input  logic                 rtc_in_i,
  output logic                 pit_en_o,
  output logic [NUM_LINES-1:0] set_o,
  output logic [NUM_LINES-1:0] drop_o
);

  logic leg_q;
  logic pit_q;
  logic rtc_q;
  logic pit_en_q;
  logic leg_rise;
  logic leg_fall;
  logic pit_fwd;
  logic rtc_fwd;

  always_comb begin
    leg_rise = legacy_i & ~leg_q;
    leg_fall = ~legacy_i & leg_q;
    pit_fwd  = ~legacy_i & (pit_in_i ^ pit_q);
    // leaving legacy mode restores the line from the tracked level
    rtc_fwd  = ~legacy_i & ((rtc_in_i ^ rtc_q) | leg_fall);
  end

  always_comb begin
    set_o  = '0;
    drop_o = '0;
    set_o[PIT_LINE]  = pit_fwd & pit_in_i;
    drop_o[PIT_LINE] = (pit_fwd & ~pit_in_i) | leg_rise | leg_fall;
    set_o[RTC_LINE]  = rtc_fwd & rtc_in_i;
    drop_o[RTC_LINE] = (rtc_fwd & ~rtc_in_i) | leg_rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leg_q    <= 1'b0;
      pit_q    <= 1'b0;
      rtc_q    <= 1'b0;
      pit_en_q <= 1'b1;
    end else begin
      leg_q    <= legacy_i;
      pit_q    <= pit_in_i;
      rtc_q    <= rtc_in_i;
      pit_en_q <= ~legacy_i;
    end
  end

  assign pit_en_o = pit_en_q;

endmodule

// File: rtl/tir_line_bank.sv
module tir_line_bank #(
  parameter int NUM_LINES = 32,
  parameter int INV_FROM  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] pls_i,
  input  logic [NUM_LINES-1:0] drop_i,
  output logic [NUM_LINES-1:0] irq_o
);

  logic [NUM_LINES-1:0] inv;
  logic [NUM_LINES-1:0] held_q;
  logic [NUM_LINES-1:0] held_nx;
  logic [NUM_LINES-1:0] act_nx;
  logic [NUM_LINES-1:0] irq_q;

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_pol
      if (l >= INV_FROM) begin : g_low
        assign inv[l] = 1'b1;
      end else begin : g_high
        assign inv[l] = 1'b0;
      end
    end
  endgenerate

  // asserts dominate; a pulse leaves the line idle afterwards
  always_comb begin
    held_nx = set_i | (held_q & ~drop_i & ~pls_i);
    act_nx  = held_nx | pls_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      irq_q  <= inv;
    end else begin
      held_q <= held_nx;
      irq_q  <= act_nx ^ inv;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/tir_irq_router.sv
module tir_irq_router #(
  parameter int NUM_TIMERS = 4,
  parameter int ROUTE_W    = 5,
  parameter int INV_FROM   = 16,
  parameter int PIT_LINE   = 0,
  parameter int RTC_LINE   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_TIMERS-1:0]         fire_i,
  input  logic [NUM_TIMERS-1:0]         clr_i,
  input  logic [NUM_TIMERS-1:0]         tmr_en_i,
  input  logic [NUM_TIMERS-1:0]         tmr_level_i,
  input  logic [NUM_TIMERS-1:0]         tmr_msg_en_i,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] tmr_route_i,
  input  logic                          glb_en_i,
  input  logic                          legacy_i,
  input  logic                          sts_wr_i,
  input  logic [NUM_TIMERS-1:0]         sts_wdata_i,
  input  logic                          pit_in_i,
  input  logic                          rtc_in_i,
  output logic [(1<<ROUTE_W)-1:0]       irq_o,
  output logic                          pit_en_o,
  output logic [NUM_TIMERS-1:0]         sts_o
);

  localparam int NUM_LINES = 1 << ROUTE_W;

  logic [NUM_LINES-1:0] slot_set  [NUM_TIMERS];
  logic [NUM_LINES-1:0] slot_pls  [NUM_TIMERS];
  logic [NUM_LINES-1:0] slot_drop [NUM_TIMERS];
  logic [NUM_LINES-1:0] leg_set;
  logic [NUM_LINES-1:0] leg_drop;
  logic [NUM_LINES-1:0] all_set;
  logic [NUM_LINES-1:0] all_pls;
  logic [NUM_LINES-1:0] all_drop;

  generate
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_slot
      tir_timer_slot #(
        .IDX       (t),
        .ROUTE_W   (ROUTE_W),
        .LEG_LINE_A(PIT_LINE),
        .LEG_LINE_B(RTC_LINE)
      ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire_i[t]),
        .clr_i     (clr_i[t]),
        .en_i      (tmr_en_i[t]),
        .level_i   (tmr_level_i[t]),
        .msg_en_i  (tmr_msg_en_i[t]),
        .route_i   (tmr_route_i[t*ROUTE_W +: ROUTE_W]),
        .glb_en_i  (glb_en_i),
        .legacy_i  (legacy_i),
        .sts_wr_i  (sts_wr_i),
        .sts_wbit_i(sts_wdata_i[t]),
        .sts_o     (sts_o[t]),
        .set_o     (slot_set[t]),
        .pls_o     (slot_pls[t]),
        .drop_o    (slot_drop[t])
      );
    end
  endgenerate

  tir_legacy_ctl #(
    .NUM_LINES(NUM_LINES),
    .PIT_LINE (PIT_LINE),
    .RTC_LINE (RTC_LINE)
  ) u_legacy (
    .clk     (clk),
    .rst_n   (rst_n),
    .legacy_i(legacy_i),
    .pit_in_i(pit_in_i),
    .rtc_in_i(rtc_in_i),
    .pit_en_o(pit_en_o),
    .set_o   (leg_set),
    .drop_o  (leg_drop)
  );

  always_comb begin
    all_set  = leg_set;
    all_pls  = '0;
    all_drop = leg_drop;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      all_set  = all_set  | slot_set[t];
      all_pls  = all_pls  | slot_pls[t];
      all_drop = all_drop | slot_drop[t];
    end
  end

  tir_line_bank #(
    .NUM_LINES(NUM_LINES),
    .INV_FROM (INV_FROM)
  ) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (all_set),
    .pls_i (all_pls),
    .drop_i(all_drop),
    .irq_o (irq_o)
  );

endmodule

// File: rtl/tir_irq_router_chk.sv
module tir_irq_router_chk #(
  parameter int NUM_TIMERS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_TIMERS-1:0] fire_i,
  input logic [NUM_TIMERS-1:0] tmr_en_i,
  input logic [NUM_TIMERS-1:0] tmr_level_i,
  input logic [NUM_TIMERS-1:0] tmr_msg_en_i,
  input logic                  glb_en_i,
  input logic                  legacy_i,
  input logic                  sts_wr_i,
  input logic [NUM_TIMERS-1:0] sts_wdata_i,
  input logic [NUM_TIMERS-1:0] sts_o,
  input logic                  pit_en_o
);

  logic [NUM_TIMERS-1:0] live_lvl;
  logic [NUM_TIMERS-1:0] live_edge;
  logic [NUM_TIMERS-1:0] w1c_bits;

  always_comb begin
    live_lvl  = fire_i & tmr_en_i & tmr_level_i & ~tmr_msg_en_i & {NUM_TIMERS{glb_en_i}};
    live_edge = fire_i & tmr_en_i & ~tmr_level_i & ~tmr_msg_en_i & {NUM_TIMERS{glb_en_i}};
    w1c_bits  = sts_wdata_i & sts_o & ~fire_i;
  end

  AST_LEVEL_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (live_lvl != '0) |=> ((sts_o & $past(live_lvl)) == $past(live_lvl))); // R3

  AST_EDGE_KEEPS_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (live_edge != '0) |=> ((sts_o & $past(live_edge)) == '0)); // R4

  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr_i && (w1c_bits != '0)) |=> ((sts_o & $past(w1c_bits)) == '0)); // R6

  AST_TMR_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((fire_i & ~tmr_en_i) != '0) |=> ((sts_o & $past(fire_i & ~tmr_en_i)) == '0)); // R7

  AST_GLB_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_i && (fire_i != '0)) |=> ((sts_o & $past(fire_i)) == '0)); // R7

  AST_PIT_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_i |=> !pit_en_o); // R9

  AST_PIT_EN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_i |=> pit_en_o); // R9

endmodule

bind tir_irq_router tir_irq_router_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fire_i      (fire_i),
  .tmr_en_i    (tmr_en_i),
  .tmr_level_i (tmr_level_i),
  .tmr_msg_en_i(tmr_msg_en_i),
  .glb_en_i    (glb_en_i),
  .legacy_i    (legacy_i),
  .sts_wr_i    (sts_wr_i),
  .sts_wdata_i (sts_wdata_i),
  .sts_o       (sts_o),
  .pit_en_o    (pit_en_o)
);

// File: tb/test_tir_irq_router.sv
`timescale 1ns/1ps
module test_tir_irq_router;

  localparam int NT = 4;
  localparam int RW = 5;
  localparam int NL = 32;
  localparam logic [NL-1:0] INV = 32'hFFFF0000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NT-1:0]   fire = '0, clr = '0, en = '0, lvl = '0, msg = '0, wd = '0;
  logic [NT*RW-1:0] route = '0;
  logic            glb = 1'b0, leg = 1'b0, swr = 1'b0, pit = 1'b0, rtc = 1'b0;
  logic [NL-1:0]   irq_o;
  logic            pit_en_o;
  logic [NT-1:0]   sts_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [NL-1:0] m_held = '0;
  logic [NL-1:0] m_irq = INV;
  logic [NT-1:0] m_sts = '0, m_msg_q = '0;
  logic          m_leg_q = 1'b0, m_pit_q = 1'b0, m_rtc_q = 1'b0, m_pit_en = 1'b1;

  always #2.5 clk = ~clk;

  tir_irq_router i_tir_irq_router (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .clr_i(clr), .tmr_en_i(en),
    .tmr_level_i(lvl), .tmr_msg_en_i(msg), .tmr_route_i(route), .glb_en_i(glb),
    .legacy_i(leg), .sts_wr_i(swr), .sts_wdata_i(wd), .pit_in_i(pit),
    .rtc_in_i(rtc), .irq_o(irq_o), .pit_en_o(pit_en_o), .sts_o(sts_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_rt(input int t, input int r);
    route[t*RW +: RW] = RW'(r);
  endtask

  function automatic int line_of(input int t);
    if (leg && t == 0) return 0;
    if (leg && t == 1) return 8;
    return int'(route[t*RW +: RW]);
  endfunction

  // next expected state from the requirements, evaluated on current inputs
  task automatic model_step();
    logic [NL-1:0] s = '0, p = '0, d = '0, hn;
    logic [NT-1:0] ns = m_sts;
    for (int t = 0; t < NT; t++) begin
      bit armed = en[t] && glb;
      bit live  = fire[t] && armed && !msg[t];
      bit mrise = msg[t] && !m_msg_q[t];
      bit drop  = clr[t] || (swr && wd[t] && m_sts[t]) || (fire[t] && !armed) || mrise;
      int ln = line_of(t);
      if (live) begin
        if (lvl[t]) s[ln] = 1'b1; else p[ln] = 1'b1;
      end else if ((drop && !msg[t]) || mrise) begin
        d[ln] = 1'b1;
      end
      if (live && lvl[t]) ns[t] = 1'b1;
      else if (live || drop) ns[t] = 1'b0;
    end
    if (leg && !m_leg_q) begin d[0] = 1'b1; d[8] = 1'b1; end
    if (!leg && m_leg_q) d[0] = 1'b1;
    if (!leg && (pit != m_pit_q)) begin if (pit) s[0] = 1'b1; else d[0] = 1'b1; end
    if (!leg && ((rtc != m_rtc_q) || m_leg_q)) begin if (rtc) s[8] = 1'b1; else d[8] = 1'b1; end
    hn = s | (m_held & ~d & ~p);
    m_held = hn;
    m_irq = (hn | p) ^ INV;
    m_sts = ns;
    m_msg_q = msg;
    m_leg_q = leg;
    m_pit_q = pit;
    m_rtc_q = rtc;
    m_pit_en = !leg;
  endtask

  // one clock: inputs were set 1 ns after the previous edge; sample 1 ns after this one
  task automatic cyc();
    model_step();
    @(posedge clk);
    #1;
    chk(irq_o === m_irq, "R13 model lines", irq_o, m_irq);
    chk(sts_o === m_sts && pit_en_o === m_pit_en, "R13 model status",
        {27'd0, pit_en_o, sts_o}, {27'd0, m_pit_en, m_sts});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(irq_o === INV, "R5 reset lines", irq_o, INV);
    chk(sts_o === '0 && pit_en_o === 1'b1, "R5 reset status", {27'd0, pit_en_o, sts_o}, 32'h10);

    en = 4'hF; glb = 1'b1; lvl = 4'b0100;
    set_rt(0, 3); set_rt(1, 4); set_rt(2, 5); set_rt(3, 7);
    cyc();

    // R1 and R3: level fire on routed line, held
    fire[2] = 1'b1; cyc(); fire = '0;
    chk(irq_o[5] === 1'b1, "R1 route line 5", irq_o, 32'h20);
    chk(sts_o[2] === 1'b1, "R3 status set", sts_o, 4'b0100);
    cyc();
    chk(irq_o[5] === 1'b1, "R3 line held", irq_o, 32'h20);

    // R6: zero bits ignored, one bit clears
    swr = 1'b1; wd = 4'b1011; cyc();
    chk(sts_o[2] === 1'b1 && irq_o[5] === 1'b1, "R6 zero no effect", {sts_o, irq_o[27:0]}, 32'h4000_0020);
    wd = 4'b0100; cyc(); swr = 1'b0; wd = '0;
    chk(sts_o[2] === 1'b0 && irq_o[5] === 1'b0, "R6 one clears", {sts_o, irq_o[27:0]}, 32'h0);

    // R4: edge pulse one cycle
    fire[3] = 1'b1; cyc(); fire = '0;
    chk(irq_o[7] === 1'b1 && sts_o[3] === 1'b0, "R4 pulse up", {sts_o, irq_o[27:0]}, 32'h80);
    cyc();
    chk(irq_o[7] === 1'b0, "R4 pulse gone", irq_o, 32'h0);

    // R5 and R8: active-low line, clear event
    set_rt(2, 20); fire[2] = 1'b1; cyc(); fire = '0;
    chk(irq_o[20] === 1'b0 && sts_o[2] === 1'b1, "R5 active low", irq_o, INV & ~32'h0010_0000);
    clr[2] = 1'b1; cyc(); clr = '0;
    chk(irq_o[20] === 1'b1 && sts_o[2] === 1'b0, "R8 clear event", irq_o, INV);

    // R7: fire while timer or global disabled
    set_rt(2, 5); fire[2] = 1'b1; cyc();
    en[2] = 1'b0; cyc(); en[2] = 1'b1; fire = '0;
    chk(irq_o[5] === 1'b0 && sts_o[2] === 1'b0, "R7 timer off", {sts_o, irq_o[27:0]}, 32'h0);
    fire[2] = 1'b1; cyc();
    glb = 1'b0; cyc(); glb = 1'b1; fire = '0;
    chk(irq_o[5] === 1'b0 && sts_o[2] === 1'b0, "R7 global off", {sts_o, irq_o[27:0]}, 32'h0);

    // R10, R11 passthrough, R9 legacy entry
    pit = 1'b1; rtc = 1'b1; cyc();
    chk(irq_o[0] === 1'b1 && irq_o[8] === 1'b1, "R10 R11 passthrough", irq_o, 32'h101);
    leg = 1'b1; cyc();
    chk(irq_o[0] === 1'b0 && irq_o[8] === 1'b0 && pit_en_o === 1'b0, "R9 entry", {pit_en_o, irq_o[30:0]}, 32'h0);
    pit = 1'b0; cyc(); pit = 1'b1; cyc();
    chk(irq_o[0] === 1'b0, "R10 ignored in legacy", irq_o, 32'h0);
    rtc = 1'b0; cyc(); rtc = 1'b1; cyc();
    chk(irq_o[8] === 1'b0, "R11 not forwarded in legacy", irq_o, 32'h0);

    // R2: legacy reroute
    lvl = 4'b0111; fire = 4'b0111; cyc(); fire = '0;
    chk(irq_o[0] === 1'b1 && irq_o[8] === 1'b1 && irq_o[3] === 1'b0 && irq_o[4] === 1'b0
        && irq_o[5] === 1'b1, "R2 legacy routes", irq_o, 32'h121);
    clr = 4'b0111; cyc(); clr = '0;
    leg = 1'b0; cyc();
    chk(pit_en_o === 1'b1 && irq_o[0] === 1'b0 && irq_o[8] === 1'b1, "R9 exit", {pit_en_o, irq_o[30:0]}, 32'h8000_0100);

    // R12: message delivery
    fire[2] = 1'b1; cyc(); fire = '0;
    msg[2] = 1'b1; cyc();
    chk(irq_o[5] === 1'b0 && sts_o[2] === 1'b0, "R12 msg rise clears", {sts_o, irq_o[27:0]}, 32'h100);
    fire[2] = 1'b1; cyc(); fire = '0;
    chk(irq_o[5] === 1'b0 && sts_o[2] === 1'b0, "R12 msg fire silent", {sts_o, irq_o[27:0]}, 32'h100);
    msg = '0; cyc();

    // R13: assert wins over same-cycle deassert
    set_rt(3, 5); fire[2] = 1'b1; clr[3] = 1'b1; cyc(); fire = '0; clr = '0;
    chk(irq_o[5] === 1'b1, "R13 assert wins", irq_o, 32'h120);
    clr = 4'hF; cyc(); clr = '0; set_rt(3, 7);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      for (int t = 0; t < NT; t++) begin
        fire[t] = ($urandom % 4) == 0;
        clr[t]  = ($urandom % 16) == 0;
        wd[t]   = ($urandom % 2) == 0;
        if (($urandom % 32) == 0) lvl[t] = ~lvl[t];
        if (($urandom % 64) == 0) en[t]  = ~en[t];
        if (($urandom % 64) == 0) msg[t] = ~msg[t];
        if (($urandom % 48) == 0) set_rt(t, int'($urandom % 32));
      end
      swr = ($urandom % 6) == 0;
      if (($urandom % 100) == 0) glb = ~glb;
      if (($urandom % 80) == 0) leg = ~leg;
      if (($urandom % 8) == 0) pit = ~pit;
      if (($urandom % 8) == 0) rtc = ~rtc;
      cyc();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule